// File: doc/BRIEF.md
# Ones-Mod-Three and Nonzero-Even-Zeros Stream Detector

This block watches a serial line that carries one bit per clock cycle. It raises a flag whenever two conditions both hold for the bits seen since the last reset. The first condition is that the number of ones is divisible by three. The second is that the number of zeros is even and greater than zero. Typical uses are framing checks and protocol sanity monitors, where a downstream unit needs a running verdict on a bit stream without storing the stream.

Internally there are two small state machines that run side by side. One tracks the residue of the ones count modulo a parameter (three by default). The other sorts the zeros count into three classes: none yet, odd, and nonzero even. Each machine reports whether it is in its accepting state, and an AND gate joins the two reports. This behaves exactly like a nine-state product machine.

Two forms of the verdict are provided:
- The registered (Moore) flag depends only on the current pair of states.
- The early (Mealy) flag depends on the current states and the bit on the line. It goes high in the cycle whose bit carries the pair into an accepting state.

There is no handshake. The line is sampled on every rising clock edge.

Top module: `ones_zeros_residue_det`

## Requirements
- R1: `ones_ok` is 1 exactly when the number of ones accepted since reset is a multiple of 3. A 1 on `x_in` advances the residue by one and wraps from 2 to 0. A 0 leaves it unchanged.
- R2: `zeros_ok` is 1 exactly when the number of zeros accepted since reset is even and nonzero. The zero class moves none→odd, odd→even and even→odd on a 0, and holds on a 1.
- R3: `det_moore` equals `ones_ok AND zeros_ok`. It is therefore 1 exactly when the ones count is 0 mod 3 and the zeros count is even and nonzero.
- R4: `det_mealy` is 1 in a cycle with reset low exactly when the current state, together with the present `x_in`, leads into an accepting pair at the next edge. `det_moore` shows that same value one cycle later.
- R5: Reset is synchronous and active high. After an edge with `rst` high, `ones_ok` is 1, `zeros_ok` is 0 and `det_moore` is 0. `det_mealy` is 0 while `rst` is high, whatever `x_in` carries.
- R6: Streams holding (ones, zeros) counts of (0,2), (3,4) and (6,2) leave `det_moore` at 1.
- R7: A third zero turns `zeros_ok` off, and a fourth turns it on again. The zero class never returns to "none" except through reset.
- R8: A reset applied in the middle of a stream discards all earlier history. Later verdicts depend only on the bits accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Serial data bit |
| det_moore | output | 1 | Registered-state verdict |
| det_mealy | output | 1 | Early verdict for the bit now on the line |
| ones_ok | output | 1 | Ones-residue machine is at residue 0 |
| zeros_ok | output | 1 | Zero-class machine is in the nonzero-even class |

## Verification
Reset and an accepting transition can land in the same cycle. The bench provokes this by raising `rst` while driving a bit on `x_in`, and expects `det_mealy` to stay low, with both sub-machines back at their initial states one edge later. The final one and the final zero never arrive together, but the early flag of one cycle must reappear as the registered flag of the next. The bench judges this pairing on every cycle. It runs exhaustive sweeps of every 10-bit stream from reset, plus a long random stream. The expected values come from running counts kept in the bench.

// File: rtl/ozd_pkg.sv
package ozd_pkg;
  typedef enum logic [1:0] {
    ZC_NONE = 2'd0,
    ZC_ODD  = 2'd1,
    ZC_EVEN = 2'd2
  } zero_class_e;
endpackage

// File: rtl/ozd_ones_residue.sv
module ozd_ones_residue #(
  parameter int ONES_MOD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic ok_o,
  output logic ok_next_o
);
  localparam int RW = (ONES_MOD > 1) ? $clog2(ONES_MOD) : 1;
  localparam logic [RW-1:0] TOP = RW'(ONES_MOD - 1);

  logic [RW-1:0] res_q, res_d;

  always_comb begin
    res_d = res_q;
    if (bit_i) res_d = (res_q == TOP) ? '0 : res_q + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end

  assign ok_o      = (res_q == '0);
  assign ok_next_o = (res_d == '0);

  // R1: residue stays inside 0..ONES_MOD-1
  assert_res_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(res_q) < ONES_MOD);
  // R1: a zero bit leaves the residue untouched
  assert_hold_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !bit_i |=> $stable(res_q));
  // R1: a one at the top residue wraps to the accepting state
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_i && res_q == TOP) |=> ok_o);
endmodule

// File: rtl/ozd_zero_class.sv
module ozd_zero_class
  import ozd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic ok_o,
  output logic ok_next_o
);
  zero_class_e cls_q, cls_d;

  always_comb begin
    cls_d = cls_q;
    if (!bit_i) begin
      case (cls_q)
        ZC_NONE: cls_d = ZC_ODD;
        ZC_ODD:  cls_d = ZC_EVEN;
        ZC_EVEN: cls_d = ZC_ODD;
        default: cls_d = ZC_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cls_q <= ZC_NONE;
    else     cls_q <= cls_d;
  end

  assign ok_o      = (cls_q == ZC_EVEN);
  assign ok_next_o = (cls_d == ZC_EVEN);

  // R2: a one bit leaves the zero class untouched
  assert_hold_on_one_R2: assert property (@(posedge clk) disable iff (rst)
    bit_i |=> $stable(cls_q));
  // R7: odd followed by a zero becomes nonzero-even, even followed by a zero becomes odd
  assert_odd_to_even_R7: assert property (@(posedge clk) disable iff (rst)
    (cls_q == ZC_ODD && !bit_i) |=> (cls_q == ZC_EVEN));
  assert_even_to_odd_R7: assert property (@(posedge clk) disable iff (rst)
    (cls_q == ZC_EVEN && !bit_i) |=> (cls_q == ZC_ODD));
  // R7: once left, the empty class is never re-entered without reset
  assert_no_return_R7: assert property (@(posedge clk) disable iff (rst)
    (cls_q != ZC_NONE) |=> (cls_q != ZC_NONE));
endmodule

// File: rtl/ones_zeros_residue_det.sv
module ones_zeros_residue_det #(
  parameter int ONES_MOD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic det_moore,
  output logic det_mealy,
  output logic ones_ok,
  output logic zeros_ok
);
  logic ones_nx, zeros_nx;

  ozd_ones_residue #(.ONES_MOD(ONES_MOD)) ones_i (
    .clk(clk), .rst(rst), .bit_i(x_in), .ok_o(ones_ok), .ok_next_o(ones_nx)
  );

  ozd_zero_class zeros_i (
    .clk(clk), .rst(rst), .bit_i(x_in), .ok_o(zeros_ok), .ok_next_o(zeros_nx)
  );

  assign det_moore = ones_ok & zeros_ok;
  assign det_mealy = !rst & ones_nx & zeros_nx;

  // R4: the early flag reappears as the registered flag one edge later
  assert_mealy_leads_R4: assert property (@(posedge clk) disable iff (rst)
    det_mealy |=> det_moore);
  assert_mealy_low_leads_R4: assert property (@(posedge clk) disable iff (rst)
    !det_mealy |=> !det_moore);
  // R5: reset leaves both machines at their initial states
  assert_reset_state_R5: assert property (@(posedge clk)
    rst |=> (ones_ok && !zeros_ok && !det_moore));
  // R5: the early flag is masked during reset
  always_comb begin
    if (rst) assert_mealy_masked_R5: assert (!det_mealy);
  end
endmodule

// File: tb/ones_zeros_residue_det_tb_top.sv
`timescale 1ns/1ps
module ones_zeros_residue_det_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic det_moore, det_mealy, ones_ok, zeros_ok;

  int n_run  = 0;
  int n_fail = 0;
  int ones_cnt  = 0;
  int zeros_cnt = 0;

  always #4 clk = ~clk;

  ones_zeros_residue_det #(.ONES_MOD(3)) dut_i (
    .clk(clk), .rst(rst), .x_in(x_in),
    .det_moore(det_moore), .det_mealy(det_mealy),
    .ones_ok(ones_ok), .zeros_ok(zeros_ok)
  );

  function automatic bit accept(int o, int z);
    return (o % 3 == 0) && (z % 2 == 0) && (z > 0);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b (ones=%0d zeros=%0d)",
               tag, $time, act, exp, ones_cnt, zeros_cnt);
    end
  endtask

  // Called at a falling edge; drives one reset cycle with a zero on the line.
  task automatic do_reset();
    rst  = 1'b1;
    x_in = 1'b0;
    #1 check(det_mealy, 1'b0, "R5 mealy masked in reset");
    @(negedge clk);
    rst = 1'b0;
    ones_cnt  = 0;
    zeros_cnt = 0;
    check(ones_ok,   1'b1, "R5 ones_ok after reset");
    check(zeros_ok,  1'b0, "R5 zeros_ok after reset");
    check(det_moore, 1'b0, "R5 det_moore after reset");
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit b);
    int no, nz;
    no = ones_cnt + (b ? 1 : 0);
    nz = zeros_cnt + (b ? 0 : 1);
    x_in = b;
    #1 check(det_mealy, accept(no, nz), "R4 mealy");
    @(negedge clk);
    ones_cnt  = no;
    zeros_cnt = nz;
    check(ones_ok,   (ones_cnt % 3 == 0), "R1 ones_ok");
    check(zeros_ok,  (zeros_cnt % 2 == 0) && (zeros_cnt > 0), "R2 zeros_ok");
    check(det_moore, accept(ones_cnt, zeros_cnt), "R3 det_moore");
  endtask

  task automatic feed(input int n1, input int n0);
    for (int k = 0; k < n1; k++) step(1'b1);
    for (int k = 0; k < n0; k++) step(1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R6: the example count pairs
    feed(0, 2); check(det_moore, 1'b1, "R6 pair (0,2)");
    do_reset();
    feed(3, 4); check(det_moore, 1'b1, "R6 pair (3,4)");
    do_reset();
    feed(6, 2); check(det_moore, 1'b1, "R6 pair (6,2)");

    // R7: the third zero clears zeros_ok and the fourth sets it again
    do_reset();
    feed(0, 3); check(zeros_ok, 1'b0, "R7 third zero");
    step(1'b0); check(zeros_ok, 1'b1, "R7 fourth zero");

    // R8: a reset in mid-stream clears the history, then two zeros accept
    feed(2, 1);
    do_reset();
    feed(0, 2); check(det_moore, 1'b1, "R8 restart after mid reset");

    // Exhaustive sweep of every 10-bit stream from reset
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      for (int k = 0; k < 10; k++) step(p[k]);
    end

    // Long random stream, with occasional resets
    do_reset();
    for (int k = 0; k < 6000; k++) begin
      if (($urandom % 500) == 0) do_reset();
      step(1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule